// File: doc/BRIEF.md
# Serpentine SAD Search Array

This block scores every candidate position of a square search area against one current macroblock by sums of absolute differences. The host first writes the current macroblock and the reference search area into the block. It then pulses `start`. From that point the block walks all candidate offsets in a serpentine order. It goes down the first column of candidates, steps one place right, climbs the next column, and repeats. For every candidate it emits the SADs of all sixteen 4x4 sub-blocks together with the candidate's motion vector.

The reference pixels sit in a register array the size of the macroblock. Each move to a neighbouring candidate shifts that array by one line and pulls a single fresh row or column out of memory. Every other pixel is reused. Once the array has filled, the block produces one candidate per clock until the last candidate, which it marks with a done pulse. Larger partitions and the choice of best vector are made downstream from the 4x4 results.

Top module: `snake_sad_top`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `cand_valid`, `done` and `busy` are low.
- R2: For the candidate at search position (cx, cy), lane b = 4*by + bx of `sad_o` (bits b*12 to b*12+11) equals the sum, over i, j in 0..3, of |cur[4*by+i][4*bx+j] - ref[cy+4*by+i][cx+4*bx+j]|. Arrays are indexed [row][column].
- R3: The 1024 candidates come out in serpentine order. The column index cx runs from 0 to 31. Within even columns cy rises from 0 to 31, and within odd columns it falls from 31 to 0. Between two consecutive candidates exactly one coordinate changes by one.
- R4: `cand_dx` = cx - 16 and `cand_dy` = cy - 16, each as 5-bit two's complement, so both lie in -16..+15.
- R5: The first candidate is valid 18 clock edges after the edge that accepts `start`.
- R6: From the first candidate to the last, `cand_valid` is high on every consecutive cycle with no gap.
- R7: `done` is high together with `cand_valid` only on the last candidate (dx = +15, dy = -16). After that cycle `cand_valid` and `done` stay low.
- R8: `busy` rises on the edge that accepts `start` and falls on the edge that raises `done`. A `start` pulse while `busy` is high has no effect on the scan.
- R9: SAD lanes carry the full range without wrap. A sub-block with all current pixels at 255 and all reference pixels at 0 reports 4080.
- R10: Current pixels are written at `cur_addr` = 16*row + column. Reference pixels are written at (`ref_x` = column, `ref_y` = row) of the 47x47 search area. The candidate (cx, cy) places the top-left reference pixel at column cx, row cy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_we | input | 1 | Current macroblock pixel write strobe |
| cur_addr | input | 8 | Current pixel address, row*16 + column |
| cur_data | input | 8 | Current pixel value |
| ref_we | input | 1 | Reference pixel write strobe |
| ref_x | input | 6 | Reference pixel column |
| ref_y | input | 6 | Reference pixel row |
| ref_data | input | 8 | Reference pixel value |
| start | input | 1 | Begin a scan, taken only while idle |
| busy | output | 1 | Scan in progress |
| cand_valid | output | 1 | Candidate outputs valid this cycle |
| cand_dx | output | 5 | Horizontal offset, two's complement |
| cand_dy | output | 5 | Vertical offset, two's complement |
| sad_o | output | 192 | Sixteen 12-bit 4x4 sub-block SADs, lane 4*by+bx |
| done | output | 1 | Marks the last candidate |

## Verification
The bench builds the block with its default parameters: 8-bit pixels, a 16x16 macroblock, 4x4 sub-blocks and 32 positions per axis. With these values the scan covers all 32 columns, so both turn directions occur and the final upward column ends at row 0. The 255-against-0 pattern drives every lane to its 4080 ceiling. Zero, pseudo-random and gradient patterns check every lane of every candidate against a model of the search area kept inside the bench. Two further cases are directed tests: a start pulse in the middle of a scan, and a reset in the middle of a scan.

// File: rtl/snake_sad_pkg.sv
package snake_sad_pkg;
  // Operation applied to the reference pixel array each cycle
  typedef enum logic [1:0] {
    SH_HOLD = 2'd0,
    SH_UP   = 2'd1,  // rows move up, fresh row enters at the bottom
    SH_DOWN = 2'd2,  // rows move down, fresh row enters at the top
    SH_LEFT = 2'd3   // columns move left, fresh column enters at the right
  } shift_e;
endpackage

// File: rtl/ref_line_ram.sv
// Line-wide synchronous RAM with a per-pixel write lane; one full line read per cycle.
module ref_line_ram #(
  parameter int PIX_W = 8,
  parameter int LANES = 47,
  parameter int DEPTH = 47,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [LW-1:0]          wlane,
  input  logic [PIX_W-1:0]       wdata,
  input  logic [AW-1:0]          raddr,
  output logic [LANES*PIX_W-1:0] rdata
);
  logic [LANES*PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr][wlane*PIX_W +: PIX_W] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/snake_scan_ctrl.sv
// Fill sequencer and serpentine walker. Issues one line read and one shift per cycle.
module snake_scan_ctrl
  import snake_sad_pkg::*;
#(
  parameter int RANGE = 32,
  parameter int MB    = 16,
  localparam int CW   = $clog2(RANGE),
  localparam int AW   = $clog2(RANGE + MB - 1),
  localparam int FW   = $clog2(MB),
  localparam int HALF = RANGE / 2,
  localparam int END_Y = (RANGE % 2 == 0) ? 0 : RANGE - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          cmd_valid,
  output shift_e        cmd_op,
  output logic          cmd_col,
  output logic [AW-1:0] cmd_addr,
  output logic [AW-1:0] cmd_off,
  output logic          cmd_cand,
  output logic          cmd_last,
  output logic [CW-1:0] cmd_dx,
  output logic [CW-1:0] cmd_dy
);
  typedef enum logic [1:0] {PH_IDLE, PH_FILL, PH_SCAN} phase_e;

  phase_e        phase;
  logic [FW-1:0] fill_cnt;
  logic [CW-1:0] cx, cy, nx_cx, nx_cy;

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = SH_HOLD;
    cmd_col   = 1'b0;
    cmd_addr  = '0;
    cmd_off   = '0;
    cmd_cand  = 1'b0;
    cmd_last  = 1'b0;
    nx_cx     = cx;
    nx_cy     = cy;
    if (phase == PH_FILL) begin
      cmd_valid = 1'b1;
      cmd_op    = SH_UP;
      cmd_addr  = AW'(fill_cnt);
      cmd_cand  = (fill_cnt == FW'(MB - 1));
    end else if (phase == PH_SCAN) begin
      cmd_valid = 1'b1;
      cmd_cand  = 1'b1;
      if (!cx[0] && cy != CW'(RANGE - 1)) begin
        nx_cy    = cy + 1'b1;
        cmd_op   = SH_UP;
        cmd_addr = AW'(cy) + AW'(MB);
        cmd_off  = AW'(cx);
      end else if (cx[0] && cy != '0) begin
        nx_cy    = cy - 1'b1;
        cmd_op   = SH_DOWN;
        cmd_addr = AW'(cy) - 1'b1;
        cmd_off  = AW'(cx);
      end else begin
        nx_cx    = cx + 1'b1;
        cmd_op   = SH_LEFT;
        cmd_col  = 1'b1;
        cmd_addr = AW'(cx) + AW'(MB);
        cmd_off  = AW'(cy);
      end
      cmd_last = (nx_cx == CW'(RANGE - 1)) && (nx_cy == CW'(END_Y));
    end
    cmd_dx = nx_cx - CW'(HALF);
    cmd_dy = nx_cy - CW'(HALF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      fill_cnt <= '0;
      cx       <= '0;
      cy       <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase    <= PH_FILL;
          fill_cnt <= '0;
          cx       <= '0;
          cy       <= '0;
        end
        PH_FILL: begin
          fill_cnt <= fill_cnt + 1'b1;
          if (fill_cnt == FW'(MB - 1)) phase <= PH_SCAN;
        end
        PH_SCAN: begin
          cx <= nx_cx;
          cy <= nx_cy;
          if (cmd_last) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3
  snake_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SCAN && $past(phase) == PH_SCAN) |->
      ((cx == $past(cx) && (cy == $past(cy) + 1 || cy == $past(cy) - 1)) ||
       (cy == $past(cy) && cx == $past(cx) + 1)));

  // R3
  fill_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SCAN && $past(phase) == PH_FILL) |-> (cx == '0 && cy == '0));
endmodule

// File: rtl/sad_row_pe.sv
// One processing element: absolute differences over a short row slice, summed.
module sad_row_pe #(
  parameter int PIX_W = 8,
  parameter int N     = 4,
  localparam int OW   = PIX_W + $clog2(N)
) (
  input  logic [N*PIX_W-1:0] a,
  input  logic [N*PIX_W-1:0] b,
  output logic [OW-1:0]      sum
);
  always_comb begin
    sum = '0;
    for (int j = 0; j < N; j++) begin
      logic [PIX_W-1:0] pa, pb, d;
      pa = a[j*PIX_W +: PIX_W];
      pb = b[j*PIX_W +: PIX_W];
      d  = (pa > pb) ? pa - pb : pb - pa;
      sum = sum + OW'(d);
    end
  end
endmodule

// File: rtl/sad_pe_array.sv
// Current-block store, shifting reference array and the grid of row-slice PEs.
module sad_pe_array
  import snake_sad_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MB    = 16,
  parameter int SUB   = 4,
  localparam int NS    = MB / SUB,
  localparam int NSUB  = NS * NS,
  localparam int PE_W  = PIX_W + $clog2(SUB),
  localparam int SAD_W = PIX_W + $clog2(SUB * SUB),
  localparam int CA    = $clog2(MB * MB),
  localparam int RW    = $clog2(MB)
) (
  input  logic                   clk,
  input  logic                   cur_we,
  input  logic [CA-1:0]          cur_addr,
  input  logic [PIX_W-1:0]       cur_data,
  input  shift_e                 op,
  input  logic [MB*PIX_W-1:0]    line_in,
  output logic [NSUB*SAD_W-1:0]  sad_comb
);
  logic [PIX_W-1:0] cur_q [MB][MB];
  logic [PIX_W-1:0] win_q [MB][MB];
  logic [PE_W-1:0]  pe_sum [NS][NS][SUB];

  always_ff @(posedge clk) begin
    if (cur_we) cur_q[cur_addr[CA-1:RW]][cur_addr[RW-1:0]] <= cur_data;
  end

  always_ff @(posedge clk) begin
    case (op)
      SH_UP: begin
        for (int r = 0; r < MB - 1; r++)
          for (int c = 0; c < MB; c++) win_q[r][c] <= win_q[r+1][c];
        for (int c = 0; c < MB; c++) win_q[MB-1][c] <= line_in[c*PIX_W +: PIX_W];
      end
      SH_DOWN: begin
        for (int r = 1; r < MB; r++)
          for (int c = 0; c < MB; c++) win_q[r][c] <= win_q[r-1][c];
        for (int c = 0; c < MB; c++) win_q[0][c] <= line_in[c*PIX_W +: PIX_W];
      end
      SH_LEFT: begin
        for (int r = 0; r < MB; r++) begin
          for (int c = 0; c < MB - 1; c++) win_q[r][c] <= win_q[r][c+1];
          win_q[r][MB-1] <= line_in[r*PIX_W +: PIX_W];
        end
      end
      default: ;
    endcase
  end

  for (genvar by = 0; by < NS; by++) begin : g_row
    for (genvar bx = 0; bx < NS; bx++) begin : g_col
      for (genvar i = 0; i < SUB; i++) begin : g_pe
        logic [SUB*PIX_W-1:0] a_v, b_v;
        always_comb begin
          for (int j = 0; j < SUB; j++) begin
            a_v[j*PIX_W +: PIX_W] = cur_q[by*SUB+i][bx*SUB+j];
            b_v[j*PIX_W +: PIX_W] = win_q[by*SUB+i][bx*SUB+j];
          end
        end
        sad_row_pe #(.PIX_W(PIX_W), .N(SUB)) i_pe (
          .a  (a_v),
          .b  (b_v),
          .sum(pe_sum[by][bx][i])
        );
      end
    end
  end

  always_comb begin
    for (int by = 0; by < NS; by++) begin
      for (int bx = 0; bx < NS; bx++) begin
        logic [SAD_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < SUB; i++) acc = acc + SAD_W'(pe_sum[by][bx][i]);
        sad_comb[(by*NS+bx)*SAD_W +: SAD_W] = acc;
      end
    end
  end
endmodule

// File: rtl/snake_sad_top.sv
// Serpentine SAD search: line stores, controller, PE array and output registers.
module snake_sad_top
  import snake_sad_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MB    = 16,
  parameter int SUB   = 4,
  parameter int RANGE = 32,
  localparam int WIN   = RANGE + MB - 1,
  localparam int AW    = $clog2(WIN),
  localparam int CW    = $clog2(RANGE),
  localparam int NSUB  = (MB / SUB) * (MB / SUB),
  localparam int SAD_W = PIX_W + $clog2(SUB * SUB),
  localparam int CA    = $clog2(MB * MB)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cur_we,
  input  logic [CA-1:0]         cur_addr,
  input  logic [PIX_W-1:0]      cur_data,
  input  logic                  ref_we,
  input  logic [AW-1:0]         ref_x,
  input  logic [AW-1:0]         ref_y,
  input  logic [PIX_W-1:0]      ref_data,
  input  logic                  start,
  output logic                  busy,
  output logic                  cand_valid,
  output logic [CW-1:0]         cand_dx,
  output logic [CW-1:0]         cand_dy,
  output logic [NSUB*SAD_W-1:0] sad_o,
  output logic                  done
);
  localparam logic [CW-1:0] MV_MIN = CW'(RANGE / 2);

  logic          cmd_valid, cmd_col, cmd_cand, cmd_last;
  shift_e        cmd_op;
  logic [AW-1:0] cmd_addr, cmd_off;
  logic [CW-1:0] cmd_dx, cmd_dy;

  logic [WIN*PIX_W-1:0] row_rd, col_rd;
  logic [MB*PIX_W-1:0]  line_sel;
  logic [NSUB*SAD_W-1:0] sad_comb;

  logic          s1_valid, s1_col, s1_cand, s1_last;
  shift_e        s1_op, arr_op;
  logic [AW-1:0] s1_off;
  logic [CW-1:0] s1_dx, s1_dy;
  logic          s2_cand, s2_last;
  logic [CW-1:0] s2_dx, s2_dy;

  snake_scan_ctrl #(.RANGE(RANGE), .MB(MB)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start && !busy),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_col  (cmd_col),
    .cmd_addr (cmd_addr),
    .cmd_off  (cmd_off),
    .cmd_cand (cmd_cand),
    .cmd_last (cmd_last),
    .cmd_dx   (cmd_dx),
    .cmd_dy   (cmd_dy)
  );

  // Row-major copy serves vertical steps, column-major copy serves the sideways step
  ref_line_ram #(.PIX_W(PIX_W), .LANES(WIN), .DEPTH(WIN)) i_row_ram (
    .clk  (clk),
    .we   (ref_we),
    .waddr(ref_y),
    .wlane(ref_x),
    .wdata(ref_data),
    .raddr(cmd_addr),
    .rdata(row_rd)
  );

  ref_line_ram #(.PIX_W(PIX_W), .LANES(WIN), .DEPTH(WIN)) i_col_ram (
    .clk  (clk),
    .we   (ref_we),
    .waddr(ref_x),
    .wlane(ref_y),
    .wdata(ref_data),
    .raddr(cmd_addr),
    .rdata(col_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_cand  <= 1'b0;
      s1_last  <= 1'b0;
    end else begin
      s1_valid <= cmd_valid;
      s1_cand  <= cmd_cand;
      s1_last  <= cmd_last;
    end
    s1_op  <= cmd_op;
    s1_col <= cmd_col;
    s1_off <= cmd_off;
    s1_dx  <= cmd_dx;
    s1_dy  <= cmd_dy;
  end

  assign line_sel = s1_col ? col_rd[s1_off*PIX_W +: MB*PIX_W]
                           : row_rd[s1_off*PIX_W +: MB*PIX_W];
  assign arr_op   = s1_valid ? s1_op : SH_HOLD;

  sad_pe_array #(.PIX_W(PIX_W), .MB(MB), .SUB(SUB)) i_array (
    .clk     (clk),
    .cur_we  (cur_we),
    .cur_addr(cur_addr),
    .cur_data(cur_data),
    .op      (arr_op),
    .line_in (line_sel),
    .sad_comb(sad_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_cand    <= 1'b0;
      s2_last    <= 1'b0;
      cand_valid <= 1'b0;
      done       <= 1'b0;
      busy       <= 1'b0;
    end else begin
      s2_cand    <= s1_valid && s1_cand;
      s2_last    <= s1_valid && s1_last;
      cand_valid <= s2_cand;
      done       <= s2_cand && s2_last;
      if (start && !busy) busy <= 1'b1;
      else if (s2_last)   busy <= 1'b0;
    end
    s2_dx   <= s1_dx;
    s2_dy   <= s1_dy;
    cand_dx <= s2_dx;
    cand_dy <= s2_dy;
    sad_o   <= sad_comb;
  end

  // R7
  done_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> cand_valid);

  // R6
  no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && !done) |=> cand_valid);

  // R4
  first_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cand_valid) |-> (cand_dx == MV_MIN && cand_dy == MV_MIN));

  // R3
  mv_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && !done) |=>
      ((cand_dx == $past(cand_dx) &&
        (cand_dy == CW'($past(cand_dy) + 1'b1) || cand_dy == CW'($past(cand_dy) - 1'b1))) ||
       (cand_dy == $past(cand_dy) && cand_dx == CW'($past(cand_dx) + 1'b1))));

  // R8
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (cand_valid && !done) |-> busy);
endmodule

// File: tb/test_snake_sad_top.sv
module test_snake_sad_top;
  localparam int CLK_PERIOD = 10;
  localparam int MB    = 16;
  localparam int SUB   = 4;
  localparam int RANGE = 32;
  localparam int WIN   = RANGE + MB - 1;
  localparam int NCAND = RANGE * RANGE;
  localparam int SAD_W = 12;

  // cur_kind, ref_kind, seed, poke start mid-scan
  localparam int PAT [4][4] = '{
    '{0, 0, 0, 0},
    '{1, 1, 5, 1},
    '{2, 0, 0, 0},
    '{3, 1, 9, 0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cur_we = 1'b0;
  logic [7:0]   cur_addr = '0;
  logic [7:0]   cur_data = '0;
  logic         ref_we = 1'b0;
  logic [5:0]   ref_x = '0, ref_y = '0;
  logic [7:0]   ref_data = '0;
  logic         start = 1'b0;
  logic         busy, cand_valid, done;
  logic [4:0]   cand_dx, cand_dy;
  logic [191:0] sad_o;

  int checks = 0;
  int errors = 0;
  int cur_px [MB][MB];
  int ref_px [WIN][WIN];

  always #(CLK_PERIOD/2) clk = ~clk;

  snake_sad_top i_snake_sad_top (
    .clk(clk), .rst(rst),
    .cur_we(cur_we), .cur_addr(cur_addr), .cur_data(cur_data),
    .ref_we(ref_we), .ref_x(ref_x), .ref_y(ref_y), .ref_data(ref_data),
    .start(start), .busy(busy), .cand_valid(cand_valid),
    .cand_dx(cand_dx), .cand_dy(cand_dy), .sad_o(sad_o), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gen(int kind, int seed, int x, int y);
    case (kind)
      0: return 0;
      1: return ((x*73 + y*151 + seed*29) ^ (x*y*7)) & 255;
      2: return 255;
      default: return (x*16 + y*3) & 255;
    endcase
  endfunction

  function automatic int exp_sad(int cx, int cy, int b);
    int bx = b % (MB/SUB);
    int by = b / (MB/SUB);
    int s = 0;
    for (int i = 0; i < SUB; i++)
      for (int j = 0; j < SUB; j++) begin
        int d = cur_px[by*SUB+i][bx*SUB+j] - ref_px[cy+by*SUB+i][cx+bx*SUB+j];
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  // R10: load both pixel stores through the write ports
  task automatic load(input int ck, input int rk, input int seed);
    for (int r = 0; r < MB; r++)
      for (int c = 0; c < MB; c++) begin
        cur_px[r][c] = gen(ck, seed, c, r);
        @(negedge clk);
        cur_we = 1'b1; cur_addr = 8'(r*MB + c); cur_data = 8'(cur_px[r][c]);
        @(posedge clk);
      end
    for (int y = 0; y < WIN; y++)
      for (int x = 0; x < WIN; x++) begin
        ref_px[y][x] = gen(rk, seed + 77, x, y);
        @(negedge clk);
        cur_we = 1'b0;
        ref_we = 1'b1; ref_x = 6'(x); ref_y = 6'(y); ref_data = 8'(ref_px[y][x]);
        @(posedge clk);
      end
    @(negedge clk);
    cur_we = 1'b0; ref_we = 1'b0;
  endtask

  task automatic run_scan(input bit poke);
    int lat = 0;
    int ecx = 0, ecy = 0;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R8", "busy after start", busy, 1);
    while (1) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (cand_valid || lat > 100) break;
    end
    check(lat == MB + 2, "R5", "first candidate latency", lat, MB + 2);
    for (int idx = 0; idx < NCAND; idx++) begin
      int bad_b = -1, act = 0, exp = 0;
      if (idx > 0) begin @(posedge clk); @(negedge clk); end
      start = (poke && idx == 100);
      check(cand_valid == 1'b1, "R6", "valid in run", cand_valid, 1);
      check(cand_dx == 5'(ecx - 16) && cand_dy == 5'(ecy - 16), "R3 R4", "mv dx*64+dy",
            int'(cand_dx)*64 + int'(cand_dy), ((ecx-16)&31)*64 + ((ecy-16)&31));
      for (int b = 0; b < 16; b++) begin
        int e = exp_sad(ecx, ecy, b);
        if (bad_b < 0 && int'(sad_o[b*SAD_W +: SAD_W]) != e) begin
          bad_b = b; act = int'(sad_o[b*SAD_W +: SAD_W]); exp = e;
        end
      end
      check(bad_b < 0, "R2 R9", $sformatf("sad lane %0d cand %0d", bad_b, idx), act, exp);
      check(done == (idx == NCAND - 1), "R7", "done flag", done, idx == NCAND - 1);
      check(busy == (idx != NCAND - 1), "R8", "busy during scan", busy, idx != NCAND - 1);
      if (ecx % 2 == 0) begin
        if (ecy < RANGE - 1) ecy++; else ecx++;
      end else begin
        if (ecy > 0) ecy--; else ecx++;
      end
    end
    start = 1'b0;
    @(posedge clk); @(negedge clk);
    check(cand_valid == 1'b0 && done == 1'b0, "R7", "quiet after last", cand_valid + done, 0);
    check(busy == 1'b0, "R8", "idle after last", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cand_valid == 1'b0 && done == 1'b0 && busy == 1'b0, "R1", "outputs in reset",
          cand_valid + done + busy, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(cand_valid == 1'b0 && done == 1'b0 && busy == 1'b0, "R1", "outputs after reset",
          cand_valid + done + busy, 0);

    for (int p = 0; p < 4; p++) begin
      load(PAT[p][0], PAT[p][1], PAT[p][2]);
      run_scan(PAT[p][3] != 0);
    end

    // R9: all-255 against all-0 gives the 4080 ceiling on every lane
    load(2, 0, 0);
    run_scan(1'b0);

    // R1: reset in mid-scan clears outputs, then a fresh scan still runs correctly
    @(negedge clk); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    repeat (50) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(cand_valid == 1'b0 && done == 1'b0 && busy == 1'b0, "R1", "outputs after mid reset",
          cand_valid + done + busy, 0);
    rst = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(cand_valid == 1'b0 && busy == 1'b0, "R1", "idle after mid reset",
          cand_valid + busy, 0);
    run_scan(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule